// File: doc/BRIEF.md
# Exact-Ratio Tick Generator

This block issues single-cycle enable ticks at a programmable average rate. The rate does not have to be an integer division of the clock. Software or a controller loads a numerator N and a denominator M with one strobe. In ratio mode the block then emits exactly N ticks in every M clocks, spaced as evenly as the integer grid allows.

Ratio mode works by error accumulation. Each clock adds N to a residue. When the residue reaches M, M is taken away and a tick is issued. The loaded strobe seeds the residue at half of M, so the ticks sit centred in their slots.

A second engine runs in parallel. It adds a fixed phase increment on every clock and presents the top bit of its phase register. This gives a square wave whose frequency is linear in the increment. A mode pin picks which engine drives the output. A typical use is to trigger a one-shot from the ratio-mode tick.

Top module: `ratio_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tick` is 0 in both modes.
- R2: A clock edge with `load` high captures `num`, `den` and `inc`. It sets the residue to floor(den/2), clears the phase register and clears the ratio tick. In the cycle that follows, `tick` is 0 in both modes.
- R3: With 0 < N < M in ratio mode, the tick sampled k clocks after the load edge is 1 exactly when floor((floor(M/2)+k·N)/M) differs from floor((floor(M/2)+(k-1)·N)/M).
- R4: With 0 < N < M in ratio mode, every run of M consecutive ticked cycles after a load contains exactly N ticks.
- R5: With N = 0 in ratio mode, no tick is ever emitted, whatever M is.
- R6: With N ≥ M and N > 0 in ratio mode, including M = 0, a tick is emitted on every clock.
- R7: In phase mode (`mode` = 0), k clocks after the load edge the phase register holds (k·inc) mod 2^PW, and `tick` equals its bit PW-1.
- R8: In phase mode with inc < 2^(PW-1), the output falls from 1 to 0 exactly inc times in the 2^PW clocks after a load. The output frequency is therefore linear in inc.
- R9: `mode` = 1 selects the ratio engine and `mode` = 0 selects the phase engine. Both engines keep running, and the selection acts on `tick` in the same cycle without a clock edge.
- R10: Changes on `num`, `den` and `inc` while `load` is low have no effect on `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Strobe that captures the settings and restarts both engines |
| mode | input | 1 | 1 selects ratio ticks, 0 selects the phase MSB |
| num | input | W | Ticks per window (N) |
| den | input | W | Window length in clocks (M) |
| inc | input | PW | Phase increment per clock |
| tick | output | 1 | Selected output |

## Verification
A wrong residue shows up as a tick that is displaced from the closed-form position. The displacement appears within one window of M clocks after the load. Because the residue must return to the same value after M clocks, any drift in it also changes a window count. A stray phase bit or a missed increment shifts the MSB edges immediately. It also changes the number of falling edges counted over one full phase wrap.

// File: rtl/ratio_tick_gen.sv
module ratio_tick_gen #(
  parameter int W  = 8,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          mode,
  input  logic [W-1:0]  num,
  input  logic [W-1:0]  den,
  input  logic [PW-1:0] inc,
  output logic          tick
);

  logic [W-1:0]  n_q, m_q, err_q;
  logic [PW-1:0] inc_q, acc_q;
  logic          bres_q;
  logic [W:0]    sum, over;
  logic          none, full, hit;

  assign sum  = {1'b0, err_q} + {1'b0, n_q};
  assign over = sum - {1'b0, m_q};
  assign none = (n_q == '0);
  assign full = !none && (n_q >= m_q);
  assign hit  = !none && (full || (sum >= {1'b0, m_q}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      m_q    <= '0;
      err_q  <= '0;
      inc_q  <= '0;
      acc_q  <= '0;
      bres_q <= 1'b0;
    end else if (load) begin
      n_q    <= num;
      m_q    <= den;
      err_q  <= den >> 1;
      inc_q  <= inc;
      acc_q  <= '0;
      bres_q <= 1'b0;
    end else begin
      acc_q  <= acc_q + inc_q;
      bres_q <= hit;
      if (!none && !full)
        err_q <= hit ? over[W-1:0] : sum[W-1:0];
    end
  end

  assign tick = mode ? bres_q : acc_q[PW-1];

endmodule

// File: rtl/ratio_tick_gen_checker.sv
module ratio_tick_gen_checker #(
  parameter int W  = 8,
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [W-1:0]  den,
  input logic [W-1:0]  n_q,
  input logic [W-1:0]  m_q,
  input logic [W-1:0]  err_q,
  input logic [PW-1:0] inc_q,
  input logic [PW-1:0] acc_q,
  input logic          bres_q
);

  p_load_center_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (err_q == ($past(den) >> 1)) && !bres_q && (acc_q == '0));

  p_residue_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q != '0 && n_q < m_q) |-> (err_q < m_q));

  p_zero_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && n_q == '0) |=> !bres_q);

  p_full_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && n_q != '0 && n_q >= m_q) |=> bres_q);

  p_phase_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (acc_q == $past(acc_q + inc_q)));

endmodule

bind ratio_tick_gen ratio_tick_gen_checker #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .den(den),
  .n_q(n_q), .m_q(m_q), .err_q(err_q), .inc_q(inc_q),
  .acc_q(acc_q), .bres_q(bres_q)
);

// File: tb/test_ratio_tick_gen.sv
`timescale 1ns/1ps
module test_ratio_tick_gen;
  localparam int W  = 8;
  localparam int PW = 12;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          load = 0;
  logic          mode = 1;
  logic [W-1:0]  num = '0;
  logic [W-1:0]  den = '0;
  logic [PW-1:0] inc = '0;
  logic          tick;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  ratio_tick_gen #(.W(W), .PW(PW)) i_ratio_tick_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .mode(mode),
    .num(num), .den(den), .inc(inc), .tick(tick)
  );

  always #2.5 clk = ~clk;

  task automatic check(input int got, input int exp, input string req);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int ratio_exp(input int n, input int m, input int k);
    int h;
    if (n == 0) return 0;
    if (n >= m) return 1;
    h = m / 2;
    return ((h + k * n) / m != (h + (k - 1) * n) / m) ? 1 : 0;
  endfunction

  function automatic int phase_exp(input int i, input int k);
    return (((k * i) % (1 << PW)) >> (PW - 1)) & 1;
  endfunction

  task automatic do_load(input int n, input int m, input int i);
    @(negedge clk);
    num = W'(n); den = W'(m); inc = PW'(i); load = 1;
    @(negedge clk);
    load = 0;
    num = ~num; den = ~den; inc = ~inc;
  endtask

  initial begin
    int seq [64];
    mode = 1;
    #1;
    check(tick, 0, "R1 reset ratio");
    mode = 0; #1;
    check(tick, 0, "R1 reset phase");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(tick, 0, "R1 after reset phase");
    mode = 1; #1;
    check(tick, 0, "R1 after reset ratio");

    for (int m = 0; m <= 12; m++) begin
      for (int n = 0; n <= m + 2; n++) begin
        int len;
        len = 3 * ((m > 0) ? m : 1);
        mode = 1;
        do_load(n, m, 0);
        check(tick, 0, "R2 ratio cleared after load");
        for (int k = 1; k <= len; k++) begin
          @(negedge clk);
          seq[k] = tick;
          if (n == 0)       check(tick, 0, "R5 zero rate R10");
          else if (n >= m)  check(tick, 1, "R6 full rate R10");
          else              check(tick, ratio_exp(n, m, k), "R3 tick position R10");
        end
        if (n > 0 && n < m) begin
          for (int s = 1; s + m - 1 <= len; s++) begin
            int c;
            c = 0;
            for (int j = s; j < s + m; j++) c += seq[j];
            check(c, n, "R4 window count");
          end
        end
      end
    end

    for (int t = 0; t < 4; t++) begin
      int iv, falls, prev;
      iv = (t == 0) ? 1 : (t == 1) ? 5 : (t == 2) ? 100 : 2047;
      mode = 0;
      do_load(0, 0, iv);
      check(tick, 0, "R2 phase cleared after load");
      prev = 0; falls = 0;
      for (int k = 1; k <= (1 << PW); k++) begin
        @(negedge clk);
        check(tick, phase_exp(iv, k), "R7 phase msb R10");
        if (prev == 1 && tick == 0) falls++;
        prev = tick;
      end
      check(falls, iv, "R8 falling edges per wrap");
    end

    do_load(1, 3, 1024);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      mode = 1; #0.5;
      check(tick, ratio_exp(1, 3, k), "R9 select ratio");
      mode = 0; #0.5;
      check(tick, phase_exp(1024, k), "R9 select phase");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule